// File: doc/BRIEF.md
# Dual-Clock FIFO Status Flag Generator

This block produces the status flags for a FIFO whose writer and reader run on unrelated clocks. It keeps a write pointer in the write-clock domain and a read pointer in the read-clock domain. Each pointer reaches the other domain as a Gray code through a multi-flop synchronizer. The memory array itself sits outside the block and takes the two addresses this block puts out.

Three active-low or active-high flags come out:
- `in_rdy` and `af_n` are timed to the write clock.
- `ae_n` is timed to the read clock.

A flag that turns toward "busy" does so in the same cycle as the local event, because it is computed from the local pointer. A flag that clears waits for the remote pointer to pass through the synchronizer. A word moved into the FIFO's output register counts as read.

The almost-empty and almost-full thresholds come from two offset registers. Reset loads them with parameter presets. After reset, each can be reloaded in parallel from the domain whose flag uses it.

Top module: `fifo_flag_gen`

## Requirements
- R1: After reset, `in_rdy` is 1, `af_n` is 1, `ae_n` is 0, and both `wr_addr` and `rd_addr` are 0.
- R2: A write request while `in_rdy` is 0 is ignored: `wr_ack` stays 0 and `wr_addr` does not advance.
- R3: `in_rdy` goes to 0 right after the write-clock edge that stores the DEPTH-th word.
- R4: After a read from a full FIFO, `in_rdy` returns to 1 on the second rising write-clock edge after that read, and not on the first.
- R5: `ae_n` is 0 when the FIFO holds X words or fewer, and 1 when it holds X+1 or more. X is the almost-empty offset, and its preset is `AE_PRESET`.
- R6: After the write that brings the count to X+1, `ae_n` rises on the second rising read-clock edge after that write, and not on the first.
- R7: `af_n` is 0 when the count is at least DEPTH−Y and 1 when the count is at most DEPTH−Y−1. It falls right after the write edge that reaches DEPTH−Y. Y is the almost-full offset, and its preset is `AF_PRESET`.
- R8: After the read that brings the count down to DEPTH−Y−1, `af_n` rises on the second rising write-clock edge after that read, and not on the first.
- R9: A read request while the FIFO is empty is ignored: `rd_ack` stays 0 and `rd_addr` does not advance.
- R10: `ae_ld` loads X from `ae_val` at a read-clock edge, and `af_ld` loads Y from `af_val` at a write-clock edge. Each new threshold applies at once. Reset restores both presets.
- R11: Words leave in the order they entered: the sequence of `rd_addr` values on accepted reads equals the sequence of `wr_addr` values on accepted writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_req | input | 1 | Write request |
| wr_ack | output | 1 | Write accepted this cycle |
| wr_addr | output | ADDR_W | Memory address for the next write |
| in_rdy | output | 1 | 1 when at least one location is free |
| af_n | output | 1 | Almost-full, active low |
| af_ld | input | 1 | Load almost-full offset |
| af_val | input | ADDR_W | New almost-full offset Y |
| rd_req | input | 1 | Read request (move a word to the output register) |
| rd_ack | output | 1 | Read accepted this cycle |
| rd_addr | output | ADDR_W | Memory address for the next read |
| ae_n | output | 1 | Almost-empty, active low |
| ae_ld | input | 1 | Load almost-empty offset |
| ae_val | input | ADDR_W | New almost-empty offset X |

## Verification
The assertions assume the following about the inputs:
- `wr_req`, `af_ld` and `af_val` change only away from rising edges of `wr_clk`.
- `rd_req`, `ae_ld` and `ae_val` change only away from rising edges of `rd_clk`.
- The two clocks never rise at the same instant, so that every synchronizer capture is clean.

The stimulus keeps to these assumptions in two ways. It drives each input on the falling edge of its own clock. It offsets the read clock by 2 ns from the write clock, with both at 10 ns. That fixed offset makes "second edge after the event" land on a predictable edge, and the timing checks count edges from there.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;

   localparam int unsigned PTR_MAX_W = 32;

   function automatic logic [PTR_MAX_W-1:0] bin2gray(input logic [PTR_MAX_W-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [PTR_MAX_W-1:0] gray2bin(input logic [PTR_MAX_W-1:0] g);
      logic [PTR_MAX_W-1:0] b;
      b[PTR_MAX_W-1] = g[PTR_MAX_W-1];
      for (int i = PTR_MAX_W - 2; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/ffg_ptr.sv
module ffg_ptr
   import fifo_flag_pkg::*;
#(
   parameter int unsigned PW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   output logic [PW-1:0] bin,
   output logic [PW-1:0] gray
);
   logic [PW-1:0] bin_nxt;

   assign bin_nxt = bin + PW'(1);

   // gray is registered directly so the crossing bus never glitches
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bin  <= '0;
         gray <= '0;
      end else if (inc) begin
         bin  <= bin_nxt;
         gray <= PW'(bin2gray(PTR_MAX_W'(bin_nxt)));
      end
   end
endmodule

// File: rtl/ffg_sync.sv
module ffg_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/ffg_ofs.sv
module ffg_ofs #(
   parameter int unsigned W      = 3,
   parameter int unsigned PRESET = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] val,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= W'(PRESET);
      else if (ld) q <= val;
   end
endmodule

// File: rtl/fifo_flag_gen.sv
module fifo_flag_gen
   import fifo_flag_pkg::*;
#(
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned AE_PRESET   = 2,
   parameter int unsigned AF_PRESET   = 2
) (
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              wr_req,
   output logic              wr_ack,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              in_rdy,
   output logic              af_n,
   input  logic              af_ld,
   input  logic [ADDR_W-1:0] af_val,
   input  logic              rd_req,
   output logic              rd_ack,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              ae_n,
   input  logic              ae_ld,
   input  logic [ADDR_W-1:0] ae_val
);
   localparam int unsigned DEPTH = 1 << ADDR_W;
   localparam int unsigned PW    = ADDR_W + 1;   // extra bit separates full from empty

   // elaboration-time parameter checks
   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr_w
      $error("fifo_flag_gen: ADDR_W must lie in 2..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("fifo_flag_gen: SYNC_STAGES must be at least 2");
   end
   if (AE_PRESET >= DEPTH || AF_PRESET >= DEPTH) begin : g_bad_preset
      $error("fifo_flag_gen: offset presets must be below DEPTH");
   end

   // ---------------- write domain ----------------
   logic [PW-1:0]     wbin, wgray, rgray_w, rbin_w, wcnt;
   logic [ADDR_W-1:0] af_ofs;

   ffg_ptr #(.PW(PW)) u_wptr (
      .clk(wr_clk), .rst_n(rst_n), .inc(wr_ack), .bin(wbin), .gray(wgray));

   ffg_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
      .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_w));

   ffg_ofs #(.W(ADDR_W), .PRESET(AF_PRESET)) u_af_ofs (
      .clk(wr_clk), .rst_n(rst_n), .ld(af_ld), .val(af_val), .q(af_ofs));

   assign rbin_w  = PW'(gray2bin(PTR_MAX_W'(rgray_w)));
   assign wcnt    = wbin - rbin_w;
   assign in_rdy  = (wcnt != PW'(DEPTH));
   assign wr_ack  = wr_req & in_rdy;
   assign af_n    = (wcnt < (PW'(DEPTH) - {1'b0, af_ofs}));
   assign wr_addr = wbin[ADDR_W-1:0];

   // ---------------- read domain ----------------
   logic [PW-1:0]     rbin, rgray, wgray_r, wbin_r, rcnt;
   logic [ADDR_W-1:0] ae_ofs;

   ffg_ptr #(.PW(PW)) u_rptr (
      .clk(rd_clk), .rst_n(rst_n), .inc(rd_ack), .bin(rbin), .gray(rgray));

   ffg_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
      .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_r));

   ffg_ofs #(.W(ADDR_W), .PRESET(AE_PRESET)) u_ae_ofs (
      .clk(rd_clk), .rst_n(rst_n), .ld(ae_ld), .val(ae_val), .q(ae_ofs));

   assign wbin_r  = PW'(gray2bin(PTR_MAX_W'(wgray_r)));
   assign rcnt    = wbin_r - rbin;
   assign rd_ack  = rd_req & (rcnt != '0);
   assign ae_n    = (rcnt > {1'b0, ae_ofs});
   assign rd_addr = rbin[ADDR_W-1:0];
endmodule

// File: rtl/ffg_chk.sv
module ffg_chk #(
   parameter int unsigned ADDR_W = 3
) (
   input logic              wr_clk,
   input logic              rd_clk,
   input logic              rst_n,
   input logic              wr_req,
   input logic              wr_ack,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              in_rdy,
   input logic              af_n,
   input logic              af_ld,
   input logic              rd_ack,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              ae_n,
   input logic              ae_ld
);
   AST_WR_BLOCKED: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_req && !in_rdy) |=> $stable(wr_addr));                        // R2

   AST_RDY_FALL_ON_WRITE: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $fell(in_rdy) |-> $past(wr_ack));                                 // R3

   AST_FULL_IMPLIES_AF: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !in_rdy |-> !af_n);                                               // R7

   AST_AF_FALL_CAUSE: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $fell(af_n) |-> ($past(wr_ack) || $past(af_ld)));                 // R7

   AST_AE_FALL_CAUSE: assert property (@(posedge rd_clk) disable iff (!rst_n)
      $fell(ae_n) |-> ($past(rd_ack) || $past(ae_ld)));                 // R5

   AST_RD_BLOCKED: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !rd_ack |=> $stable(rd_addr));                                    // R9
endmodule

bind fifo_flag_gen ffg_chk #(.ADDR_W(ADDR_W)) u_chk (
   .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
   .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr), .in_rdy(in_rdy),
   .af_n(af_n), .af_ld(af_ld), .rd_ack(rd_ack), .rd_addr(rd_addr),
   .ae_n(ae_n), .ae_ld(ae_ld));

// File: tb/fifo_flag_gen_tb.sv
`timescale 1ns/1ps
module fifo_flag_gen_tb;
   localparam int AW    = 3;
   localparam int DEPTH = 1 << AW;

   logic wr_clk = 0, rd_clk = 0, rst_n = 0;
   logic wr_req = 0, rd_req = 0, af_ld = 0, ae_ld = 0;
   logic [AW-1:0] af_val = '0, ae_val = '0;
   logic wr_ack, rd_ack, in_rdy, af_n, ae_n;
   logic [AW-1:0] wr_addr, rd_addr;

   int checks = 0, fails = 0;
   int q[$];

   always #5 wr_clk = ~wr_clk;
   initial begin #2; forever #5 rd_clk = ~rd_clk; end

   fifo_flag_gen #(.ADDR_W(AW), .SYNC_STAGES(2), .AE_PRESET(2), .AF_PRESET(2)) u_dut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
      .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr), .in_rdy(in_rdy),
      .af_n(af_n), .af_ld(af_ld), .af_val(af_val),
      .rd_req(rd_req), .rd_ack(rd_ack), .rd_addr(rd_addr), .ae_n(ae_n),
      .ae_ld(ae_ld), .ae_val(ae_val));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // driver: writes one word and records the expected slot order
   task automatic wpush();
      @(negedge wr_clk) wr_req = 1;
      #1 if (wr_ack) q.push_back(int'(wr_addr));
      @(posedge wr_clk); #1 wr_req = 0;
   endtask

   task automatic rpop();
      @(negedge rd_clk) rd_req = 1;
      @(posedge rd_clk); #1 rd_req = 0;
   endtask

   task automatic wedge(input int n);
      for (int i = 0; i < n; i++) begin @(posedge wr_clk); #1; end
   endtask

   task automatic redge(input int n);
      for (int i = 0; i < n; i++) begin @(posedge rd_clk); #1; end
   endtask

   // monitor: pops expected order and compares on each accepted read
   always @(negedge rd_clk) begin
      #1;
      if (rd_req && rd_ack) begin
         if (q.size() == 0) chk("R11 read with empty scoreboard", 1, 0);
         else chk("R11 read order", int'(rd_addr), q.pop_front());
      end
   end

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #23 rst_n = 1;
      wedge(1);
      chk("R1 in_rdy", in_rdy, 1);
      chk("R1 af_n", af_n, 1);
      chk("R1 ae_n", ae_n, 0);
      chk("R1 wr_addr", int'(wr_addr), 0);
      chk("R1 rd_addr", int'(rd_addr), 0);

      // R9: read while empty
      @(negedge rd_clk) rd_req = 1;
      #1 chk("R9 rd_ack empty", rd_ack, 0);
      @(posedge rd_clk); #1 rd_req = 0;
      chk("R9 rd_addr held", int'(rd_addr), 0);

      // R5/R6: fill to X=2, then X+1
      wpush(); wpush();
      redge(4);
      chk("R5 ae_n at X words", ae_n, 0);
      wpush();
      redge(1);
      chk("R6 ae_n first rd edge", ae_n, 0);
      redge(1);
      chk("R6 ae_n second rd edge", ae_n, 1);

      // R7: count 5 then 6 (DEPTH-Y)
      wpush(); wpush();
      chk("R7 af_n at 5", af_n, 1);
      wpush();
      chk("R7 af_n at 6", af_n, 0);
      wpush();
      chk("R3 in_rdy at 7", in_rdy, 1);
      wpush();
      chk("R3 in_rdy at full", in_rdy, 0);

      // R2: blocked write
      @(negedge wr_clk) wr_req = 1;
      #1 chk("R2 wr_ack when full", wr_ack, 0);
      @(posedge wr_clk); #1 wr_req = 0;
      chk("R2 wr_addr held", int'(wr_addr), 0);
      chk("R2 still full", in_rdy, 0);

      // R4: one read frees a slot
      rpop();
      wedge(1);
      chk("R4 in_rdy first wr edge", in_rdy, 0);
      wedge(1);
      chk("R4 in_rdy second wr edge", in_rdy, 1);
      chk("R7 af_n at 7", af_n, 0);

      // R8: down to 6 then 5
      rpop();
      wedge(3);
      chk("R7 af_n at 6 after read", af_n, 0);
      rpop();
      wedge(1);
      chk("R8 af_n first wr edge", af_n, 0);
      wedge(1);
      chk("R8 af_n second wr edge", af_n, 1);

      // drain the rest
      rpop(); rpop();
      redge(1);
      chk("R5 ae_n at 3", ae_n, 1);
      rpop();
      chk("R5 ae_n falls at 2", ae_n, 0);
      rpop(); rpop();
      @(negedge rd_clk) rd_req = 1;
      #1 chk("R9 rd_ack after drain", rd_ack, 0);
      @(posedge rd_clk); #1 rd_req = 0;
      chk("R11 scoreboard empty", q.size(), 0);

      // R10: load offsets
      @(negedge rd_clk) begin ae_ld = 1; ae_val = 3'd0; end
      @(posedge rd_clk); #1 ae_ld = 0;
      wpush();
      redge(4);
      chk("R10 ae_n with X=0, 1 word", ae_n, 1);
      wedge(3);
      chk("R10 af_n before load", af_n, 1);
      @(negedge wr_clk) begin af_ld = 1; af_val = 3'd7; end
      @(posedge wr_clk); #1 af_ld = 0;
      chk("R10 af_n with Y=7, 1 word", af_n, 0);

      // R10: reset restores presets
      @(negedge wr_clk) rst_n = 0;
      #1 q.delete();
      wedge(2);
      chk("R1 in_rdy after reset", in_rdy, 1);
      @(negedge wr_clk) rst_n = 1;
      chk("R10 af_n preset Y", af_n, 1);
      wpush(); wpush();
      redge(4);
      chk("R10 ae_n preset X, 2 words", ae_n, 0);
      rpop(); rpop();
      redge(2);
      chk("R11 scoreboard empty end", q.size(), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule